// File: doc/BRIEF.md
# CAN Error-Status Change Flag Register

This block sits beside the error counters of a CAN controller. Each cycle it sorts the receive and transmit error counts into a 2-bit bus-health code, one code per direction. It compares both codes with the copy held in its flag register. When either code differs, it loads the new codes into the register and raises a status-change flag. While that flag is pending the register copy is frozen, so the status software reads always matches the event that raised the interrupt. This holds even if the counters keep moving. A second flag records bus activity seen while the controller sleeps with wake-up enabled.

Software reads the register through `rd_data` and clears a flag by writing 1 to its bit. Two mask inputs stand in for the interrupt-enable register, and `irq` is high whenever an unmasked flag is set. While the controller is in init mode (request and acknowledge both high), both flags are held clear and writes are ignored. The stored status codes keep their values through init mode.

Top module: `can_errstat_flags`

## Requirements
- R1: Receive code: 0 when the receive count is 0 to 96, 1 when it is 97 to 127, 2 when it is above 127, and 3 when `bus_off` is high. The reported receive code sits at `rd_data[3:2]`.
- R2: Transmit code: 0 when the transmit count is 0 to 96, 1 when it is 97 to 127, 2 when it is 128 to 255, and 3 when it is above 255 or when `bus_off` is high. The reported transmit code sits at `rd_data[5:4]`, and `rd_data[7:6]` read 0.
- R3: When the status-change flag (`rd_data[1]`) is clear and a live code differs from the reported code, on the next edge the reported codes take the live values and the flag sets.
- R4: While the status-change flag is set and not being cleared, the reported codes stay unchanged, whatever the counters do.
- R5: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. Writes never change the code bits.
- R6: The wake-up flag (`rd_data[0]`) sets when `bus_activity` is high while `sleep_mode` and `wake_en` are both high, and not otherwise.
- R7: While `init_req` and `init_ack` are both high, both flags read 0 and neither writes nor events set them. Normal behaviour returns once init mode ends.
- R8: The reported codes are neither reset nor updated during init mode. If they differ from the live codes when init mode ends, the status flag sets on the next edge.
- R9: `irq` is high exactly when the wake flag is set with `wake_irq_en` high, or the status flag is set with `stat_irq_en` high.
- R10: If a write-1 clear and a set event hit the same flag in one cycle, the flag ends up set.
- R11: A clear of the status flag while a live code still differs from the reported code updates the codes and leaves the flag set.
- R12: After reset, `rd_data` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_err_cnt | input | 8 | Receive error count |
| tx_err_cnt | input | 9 | Transmit error count; bit 8 marks values above 255 |
| bus_off | input | 1 | Controller is bus-off; forces both codes to 3 |
| sleep_mode | input | 1 | Controller is in sleep |
| wake_en | input | 1 | Wake-up on bus activity enabled |
| bus_activity | input | 1 | One-cycle strobe for activity seen on the bus |
| init_req | input | 1 | Init mode requested |
| init_ack | input | 1 | Init mode acknowledged |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; 1 in bit 0 or bit 1 clears that flag |
| wake_irq_en | input | 1 | Interrupt mask for the wake flag |
| stat_irq_en | input | 1 | Interrupt mask for the status flag |
| rd_data | output | 8 | Register contents: {2'b0, tx code, rx code, status flag, wake flag} |
| irq | output | 1 | Masked interrupt request |

## Verification
Each counter is swept across its code boundaries (96/97, 127/128, 255/256) one at a time. This separates an off-by-one threshold from a swapped field, and `bus_off` checks the forced code on both fields. The counters are then moved while a status change is pending and cleared while they still differ. This tells a frozen register apart from one that follows the counters, and shows whether a clear re-latches. Write patterns with zeros in flag positions and ones in code positions separate write-1-to-clear from plain writes. Clears that coincide with wake events, and activity with sleep or enable missing, pin down set priority and the wake condition. An init-mode sequence with counter motion inside it shows flags held clear and codes retained.

// File: rtl/can_errstat_flags.sv
module can_errstat_flags #(
  parameter int REC_W    = 8,
  parameter int TEC_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int ERR_LIM  = 127,
  parameter int BO_LIM   = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REC_W-1:0] rx_err_cnt,
  input  logic [TEC_W-1:0] tx_err_cnt,
  input  logic             bus_off,
  input  logic             sleep_mode,
  input  logic             wake_en,
  input  logic             bus_activity,
  input  logic             init_req,
  input  logic             init_ack,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             wake_irq_en,
  input  logic             stat_irq_en,
  output logic [7:0]       rd_data,
  output logic             irq
);
  localparam logic [REC_W-1:0] RX_WARN = REC_W'(WARN_LIM);
  localparam logic [REC_W-1:0] RX_ERR  = REC_W'(ERR_LIM);
  localparam logic [TEC_W-1:0] TX_WARN = TEC_W'(WARN_LIM);
  localparam logic [TEC_W-1:0] TX_ERR  = TEC_W'(ERR_LIM);
  localparam logic [TEC_W-1:0] TX_BO   = TEC_W'(BO_LIM);

  logic [1:0] rx_live, tx_live, rx_rep, tx_rep;
  logic       wake_flag, stat_flag;

  always_comb begin
    if (bus_off)                 rx_live = 2'd3;
    else if (rx_err_cnt > RX_ERR)  rx_live = 2'd2;
    else if (rx_err_cnt > RX_WARN) rx_live = 2'd1;
    else                         rx_live = 2'd0;
  end

  always_comb begin
    if (bus_off || tx_err_cnt > TX_BO) tx_live = 2'd3;
    else if (tx_err_cnt > TX_ERR)      tx_live = 2'd2;
    else if (tx_err_cnt > TX_WARN)     tx_live = 2'd1;
    else                               tx_live = 2'd0;
  end

  wire in_init   = init_req & init_ack;
  wire clr_wake  = wr_en & wr_data[0];
  wire clr_stat  = wr_en & wr_data[1];
  wire wake_evt  = sleep_mode & wake_en & bus_activity;
  wire differs   = (rx_live != rx_rep) || (tx_live != tx_rep);
  wire may_latch = ~stat_flag | clr_stat;

  logic unused_wr;
  assign unused_wr = &{1'b0, wr_data[7:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_flag <= 1'b0;
      stat_flag <= 1'b0;
      rx_rep    <= 2'd0;
      tx_rep    <= 2'd0;
    end else if (in_init) begin
      wake_flag <= 1'b0;
      stat_flag <= 1'b0;
    end else begin
      wake_flag <= wake_evt | (wake_flag & ~clr_wake);
      if (may_latch && differs) begin
        rx_rep    <= rx_live;
        tx_rep    <= tx_live;
        stat_flag <= 1'b1;
      end else if (clr_stat) begin
        stat_flag <= 1'b0;
      end
    end
  end

  assign rd_data = {2'b00, tx_rep, rx_rep, stat_flag, wake_flag};
  assign irq     = (wake_flag & wake_irq_en) | (stat_flag & stat_irq_en);
endmodule

module can_errstat_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_err_cnt,
  input logic [8:0] tx_err_cnt,
  input logic       bus_off,
  input logic       sleep_mode,
  input logic       wake_en,
  input logic       bus_activity,
  input logic       init_req,
  input logic       init_ack,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       wake_irq_en,
  input logic       stat_irq_en,
  input logic [7:0] rd_data,
  input logic       irq
);
  a_r4_codes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && !(wr_en && wr_data[1])) |=> $stable(rd_data[5:2]));
  a_r7_init_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> (rd_data[1:0] == 2'b00));
  a_r8_init_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> $stable(rd_data[5:2]));
  a_r6_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!(init_req && init_ack) && sleep_mode && wake_en && bus_activity) |=> rd_data[0]);
  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!(init_req && init_ack) && wr_en && wr_data[0] && sleep_mode && wake_en && bus_activity)
      |=> rd_data[0]);
  a_r9_no_irq_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b00) |-> !irq);
  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00);
endmodule

bind can_errstat_flags can_errstat_flags_chk u_chk (.*);

// File: tb/can_errstat_flags_tb.sv
module can_errstat_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_err_cnt = '0;
  logic [8:0] tx_err_cnt = '0;
  logic       bus_off = 0, sleep_mode = 0, wake_en = 0, bus_activity = 0;
  logic       init_req = 0, init_ack = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic       wake_irq_en = 0, stat_irq_en = 0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_errstat_flags u_dut (
    .clk(clk), .rst_n(rst_n), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .bus_off(bus_off), .sleep_mode(sleep_mode), .wake_en(wake_en),
    .bus_activity(bus_activity), .init_req(init_req), .init_ack(init_ack),
    .wr_en(wr_en), .wr_data(wr_data), .wake_irq_en(wake_irq_en),
    .stat_irq_en(stat_irq_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_reg(input logic [7:0] exp, input string req);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected %02h", req, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%0b expected %0b", req, irq, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk_reg(8'h00, "R12");
    chk_irq(1'b0, "R12");
  endtask

  task automatic t_rx_codes();
    rx_err_cnt = 8'd96;  tick(); chk_reg(8'h00, "R1");
    rx_err_cnt = 8'd97;  tick(); chk_reg(8'h06, "R1");
    wr(8'h02);                   chk_reg(8'h04, "R1");
    rx_err_cnt = 8'd128; tick(); chk_reg(8'h0A, "R1");
    wr(8'h02);                   chk_reg(8'h08, "R1");
    rx_err_cnt = 8'd127; tick(); chk_reg(8'h06, "R1");
    wr(8'h02);
    rx_err_cnt = 8'd0;   tick(); chk_reg(8'h02, "R3");
    wr(8'h02);                   chk_reg(8'h00, "R3");
  endtask

  task automatic t_tx_codes();
    tx_err_cnt = 9'd96;  tick(); chk_reg(8'h00, "R2");
    tx_err_cnt = 9'd97;  tick(); chk_reg(8'h12, "R2");
    wr(8'h02);
    tx_err_cnt = 9'd255; tick(); chk_reg(8'h22, "R2");
    wr(8'h02);
    tx_err_cnt = 9'd256; tick(); chk_reg(8'h32, "R2");
    wr(8'h02);                   chk_reg(8'h30, "R2");
    tx_err_cnt = 9'd0;   tick(); chk_reg(8'h02, "R2");
    wr(8'h02);
    bus_off = 1'b1;      tick(); chk_reg(8'h3E, "R2 R1 bus_off");
    wr(8'h02);
    bus_off = 1'b0;      tick(); chk_reg(8'h02, "R2");
    wr(8'h02);                   chk_reg(8'h00, "R2");
  endtask

  task automatic t_freeze_relatch();
    rx_err_cnt = 8'd97;  tick(); chk_reg(8'h06, "R4");
    rx_err_cnt = 8'd200; tick(); chk_reg(8'h06, "R4");
    tx_err_cnt = 9'd300; tick(); chk_reg(8'h06, "R4");
    tx_err_cnt = 9'd0;
    wr(8'h02);                   chk_reg(8'h0A, "R11");
    wr(8'h02);                   chk_reg(8'h08, "R11");
    rx_err_cnt = 8'd0;   tick(); wr(8'h02); chk_reg(8'h00, "R4");
  endtask

  task automatic t_write_rules();
    rx_err_cnt = 8'd97;  tick(); chk_reg(8'h06, "R5");
    wr(8'h00);                   chk_reg(8'h06, "R5 write 0");
    wr(8'h3D);                   chk_reg(8'h06, "R5 code bits read-only");
    wr(8'h02);                   chk_reg(8'h04, "R5 write 1 clears");
    rx_err_cnt = 8'd0;   tick(); wr(8'h02); chk_reg(8'h00, "R5");
  endtask

  task automatic pulse_activity();
    bus_activity = 1'b1; tick(); bus_activity = 1'b0;
  endtask

  task automatic t_wake_irq();
    sleep_mode = 1; wake_en = 0; pulse_activity(); chk_reg(8'h00, "R6 no enable");
    sleep_mode = 0; wake_en = 1; pulse_activity(); chk_reg(8'h00, "R6 not asleep");
    sleep_mode = 1;              pulse_activity(); chk_reg(8'h01, "R6");
    chk_irq(1'b0, "R9 masked");
    wake_irq_en = 1; tick();     chk_irq(1'b1, "R9 wake");
    wr_en = 1; wr_data = 8'h01; bus_activity = 1; tick();
    wr_en = 0; wr_data = 8'h00; bus_activity = 0;
    chk_reg(8'h01, "R10");
    wr(8'h01);                   chk_reg(8'h00, "R5 wake clear");
    chk_irq(1'b0, "R9");
    wake_irq_en = 0; sleep_mode = 0; wake_en = 0;
    stat_irq_en = 1;
    rx_err_cnt = 8'd97; tick();  chk_irq(1'b1, "R9 status");
    stat_irq_en = 0;    tick();  chk_irq(1'b0, "R9 status masked");
    rx_err_cnt = 8'd0; wr(8'h02); wr(8'h02); chk_reg(8'h00, "R9");
  endtask

  task automatic t_init();
    rx_err_cnt = 8'd97; tick();  chk_reg(8'h06, "R7");
    init_req = 1;       tick();  chk_reg(8'h06, "R7 request only");
    init_ack = 1;       tick();  chk_reg(8'h04, "R7");
    sleep_mode = 1; wake_en = 1; pulse_activity();
    chk_reg(8'h04, "R7 no wake in init");
    rx_err_cnt = 8'd200; tick(); chk_reg(8'h04, "R8");
    wr(8'h03);                   chk_reg(8'h04, "R7 writes ignored");
    sleep_mode = 0; wake_en = 0;
    init_req = 0; init_ack = 0; tick(); chk_reg(8'h0A, "R8");
    wr(8'h02);                   chk_reg(8'h08, "R8");
    rx_err_cnt = 8'd0; tick(); wr(8'h02); chk_reg(8'h00, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_rx_codes();
    t_tx_codes();
    t_freeze_relatch();
    t_write_rules();
    t_wake_irq();
    t_init();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule